// File: doc/BRIEF.md
# QPSK Phase-Selection Modulator

This block turns a serial bit stream into four-phase carrier samples for an external D/A converter. Accepted bits are paired into a 2-bit symbol. A lookup holds one period of a digital carrier of eight samples. Each symbol value picks a fixed starting point in that table, a quarter period apart from the others. So in every symbol interval the output carries the carrier at one of four phases, chosen by the symbol.

The output is an 8-bit unsigned code together with a one-cycle strobe. The strobe fires once every `CLKS_PER_SAMPLE` clocks. The block is meant to run from a 4 MHz system clock. A newly paired symbol takes effect only when a whole symbol interval ends, so the carrier phase changes only on period boundaries. Between those boundaries the pair waits in a single pending slot. While no new pair arrives, the current symbol is held and the output repeats period after period.

Top module: `qpsk_modulator`

## Requirements
- R1: Two accepted bits form one symbol. The first bit received is the symbol's MSB and the second is its LSB.
- R2: `bit_in` has no effect while `bit_valid` is low.
- R3: One carrier period is 8 samples of the base waveform 0x00, 0x5A, 0x7F, 0xBF, 0xFF, 0xBF, 0x7F, 0x5A. Symbol 2'b10 starts that table at index 0, so it outputs exactly this sequence.
- R4: With the default `PHASE_MAP`, the table start index for each symbol is: 2'b00 at index 6, 2'b01 at index 4, 2'b10 at index 0, and 2'b11 at index 2. Each sample index advances by one per strobe and wraps modulo 8.
- R5: A completed pair takes effect only after the last sample of the current symbol interval. Every sample of the interval that was in progress still uses the old symbol.
- R6: While no new pair arrives, the symbol is held, and the output repeats with a period of 8 samples.
- R7: A lone bit without its partner never changes the symbol.
- R8: Synchronous active-high reset does the following. It drives `sample_code` to 0x00 and `sample_valid` low, sets the symbol to 2'b00 and discards any half-received pair. Sample numbering restarts at index 0.
- R9: `sample_valid` is high for one cycle every `CLKS_PER_SAMPLE` clocks (default 4), and `sample_code` changes only together with it.
- R10: A symbol interval lasts `SAMPLES_PER_SYM` samples, a multiple of 8 (default 8).
- R11: If two pairs complete within one interval, the later one is the one applied at the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Serial data bit |
| sample_code | output | 8 | Unsigned carrier sample for the D/A converter |
| sample_valid | output | 1 | One-cycle strobe marking a new `sample_code` |

## Verification
The bench aims at four corner cases.

- **Late pair in an interval.** A pair is delivered partway through an interval. A design that switches phase immediately would corrupt the tail of that period.
- **Lone leftover bit.** A single bit is left waiting. A design that latches half a pair would switch to a wrong symbol.
- **Reset between the two bits of a pair.** A design that keeps the stale first bit would pair it with the next bit and produce the wrong symbol.
- **Two pairs in one interval.** A design that keeps the first pair, or merges the two, would show the wrong phase in the following period.

Each symbol's phase is checked sample by sample over two periods, which would expose a wrong offset, a reversed bit order or a non-periodic hold.

// File: rtl/qpsk_pkg.sv
`timescale 1ns/1ps
package qpsk_pkg;

    localparam int WAVE_LEN = 8;
    localparam int WAVE_AW  = 3;
    localparam int CODE_W   = 8;

    typedef logic [1:0]          sym_t;
    typedef logic [CODE_W-1:0]   code_t;
    typedef logic [WAVE_AW-1:0]  widx_t;

    // a completed bit pair waiting for the next symbol boundary
    typedef struct packed {
        logic vld;
        sym_t sym;
    } pair_t;

    // one carrier period, unsigned offset-binary samples
    function automatic code_t carrier_sample(widx_t idx);
        code_t c;
        case (idx)
            3'd0:    c = 8'h00;
            3'd1:    c = 8'h5A;
            3'd2:    c = 8'h7F;
            3'd3:    c = 8'hBF;
            3'd4:    c = 8'hFF;
            3'd5:    c = 8'hBF;
            3'd6:    c = 8'h7F;
            default: c = 8'h5A;
        endcase
        return c;
    endfunction

    // quarter-period step count for a symbol, from a packed 4x2-bit map
    function automatic logic [1:0] quarter_steps(logic [7:0] map, sym_t s);
        return map[{s, 1'b0} +: 2];
    endfunction

endpackage

// File: rtl/qpsk_bit_pairer.sv
`timescale 1ns/1ps
module qpsk_bit_pairer
    import qpsk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_valid,
    input  logic  bit_in,
    input  logic  consume,
    output pair_t pending
);
    logic half_q;
    logic first_q;
    pair_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q  <= 1'b0;
            first_q <= 1'b0;
            pend_q  <= '0;
        end else begin
            if (consume)
                pend_q.vld <= 1'b0;
            if (bit_valid) begin
                if (!half_q) begin
                    first_q <= bit_in;
                    half_q  <= 1'b1;
                end else begin
                    // newest completed pair replaces any waiting one
                    pend_q.vld <= 1'b1;
                    pend_q.sym <= {first_q, bit_in};
                    half_q     <= 1'b0;
                end
            end
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/qpsk_sample_timer.sv
`timescale 1ns/1ps
module qpsk_sample_timer
    import qpsk_pkg::*;
#(
    parameter int CLKS_PER_SAMPLE = 4,
    parameter int SAMPLES_PER_SYM = 8
) (
    input  logic  clk,
    input  logic  rst,
    output logic  tick,
    output widx_t wave_idx,
    output logic  boundary
);
    localparam int DIV_W = (CLKS_PER_SAMPLE > 1) ? $clog2(CLKS_PER_SAMPLE) : 1;
    localparam int IDX_W = $clog2(SAMPLES_PER_SYM);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLES_PER_SYM - 1);

    generate
        if (CLKS_PER_SAMPLE == 1) begin : g_every_clk
            assign tick = 1'b1;
        end else begin : g_divider
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_SAMPLE - 1);
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst)
                    div_q <= '0;
                else if (div_q == DIV_LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DIV_LAST);
        end
    endgenerate

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (tick)
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end

    assign wave_idx = idx_q[WAVE_AW-1:0];
    assign boundary = tick && (idx_q == LAST_IDX);
endmodule

// File: rtl/qpsk_phase_rom.sv
`timescale 1ns/1ps
module qpsk_phase_rom
    import qpsk_pkg::*;
#(
    parameter logic [7:0] PHASE_MAP = 8'b01_00_10_11
) (
    input  sym_t  sym,
    input  widx_t wave_idx,
    output code_t code
);
    logic [1:0] quarter;
    widx_t      rd_idx;

    always_comb begin
        quarter = quarter_steps(PHASE_MAP, sym);
        rd_idx  = wave_idx + {quarter, 1'b0};
        code    = carrier_sample(rd_idx);
    end
endmodule

// File: rtl/qpsk_modulator.sv
`timescale 1ns/1ps
module qpsk_modulator
    import qpsk_pkg::*;
#(
    parameter int         CLKS_PER_SAMPLE = 4,
    parameter int         SAMPLES_PER_SYM = 8,
    parameter logic [7:0] PHASE_MAP       = 8'b01_00_10_11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_valid,
    input  logic       bit_in,
    output logic [7:0] sample_code,
    output logic       sample_valid
);
    pair_t pending;
    logic  tick;
    logic  boundary;
    logic  take;
    widx_t wave_idx;
    sym_t  sym_q;
    code_t rom_code;
    code_t code_q;
    logic  valid_q;

    assign take = boundary && pending.vld;

    qpsk_bit_pairer u_pairer (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .consume   (take),
        .pending   (pending)
    );

    qpsk_sample_timer #(
        .CLKS_PER_SAMPLE (CLKS_PER_SAMPLE),
        .SAMPLES_PER_SYM (SAMPLES_PER_SYM)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wave_idx (wave_idx),
        .boundary (boundary)
    );

    qpsk_phase_rom #(
        .PHASE_MAP (PHASE_MAP)
    ) u_rom (
        .sym      (sym_q),
        .wave_idx (wave_idx),
        .code     (rom_code)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sym_q <= '0;
        else if (take)
            sym_q <= pending.sym;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= tick;
            if (tick)
                code_q <= rom_code;
        end
    end

    assign sample_code  = code_q;
    assign sample_valid = valid_q;
endmodule

// File: rtl/qpsk_modulator_chk.sv
`timescale 1ns/1ps
module qpsk_modulator_chk #(
    parameter int CLKS_PER_SAMPLE = 4
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] sample_code,
    input logic       sample_valid,
    input logic [1:0] cur_sym,
    input logic       sym_boundary
);
    logic [15:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (sample_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (sample_code == 8'h00 && !sample_valid));

    assert_strobe_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && seen_q) |-> (gap_q == 16'(CLKS_PER_SAMPLE - 1)));

    assert_code_held_R9: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !$past(rst)) |-> $stable(sample_code));

    assert_symbol_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_sym) |-> ($past(sym_boundary) || $past(rst)));

    assert_code_in_table_R3: assert property (@(posedge clk) disable iff (rst)
        sample_code inside {8'h00, 8'h5A, 8'h7F, 8'hBF, 8'hFF});

    generate
        if (CLKS_PER_SAMPLE > 1) begin : g_width
            assert_strobe_width_R9: assert property (@(posedge clk) disable iff (rst)
                sample_valid |=> !sample_valid);
        end
    endgenerate
endmodule

bind qpsk_modulator qpsk_modulator_chk #(
    .CLKS_PER_SAMPLE (CLKS_PER_SAMPLE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_code  (sample_code),
    .sample_valid (sample_valid),
    .cur_sym      (sym_q),
    .sym_boundary (boundary)
);

// File: tb/tb_qpsk_modulator.sv
`timescale 1ns/1ps
module tb_qpsk_modulator;
    localparam int CPS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic [7:0] sample_code;
    logic       sample_valid;

    int checks = 0;
    int failures = 0;
    int sample_no = 0;
    logic [7:0] cap [0:63];

    // base carrier period and default quarter-step per symbol (R3, R4)
    logic [7:0] tbl [0:7] = '{8'h00, 8'h5A, 8'h7F, 8'hBF, 8'hFF, 8'hBF, 8'h7F, 8'h5A};
    int qmap [0:3] = '{3, 2, 0, 1};

    always #10 clk = ~clk;

    qpsk_modulator dut (
        .clk          (clk),
        .rst          (rst),
        .bit_valid    (bit_valid),
        .bit_in       (bit_in),
        .sample_code  (sample_code),
        .sample_valid (sample_valid)
    );

    always @(negedge clk) begin
        if (rst) sample_no = 0;
        else if (sample_valid) begin
            if (sample_no < 64) cap[sample_no] = sample_code;
            sample_no++;
        end
    end

    function automatic logic [7:0] exp_code(int sym, int k);
        return tbl[(k % 8 + 2 * qmap[sym]) % 8];
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(sample_code == 8'h00, "R8", "code in reset", sample_code, 0);
        chk(sample_valid == 1'b0, "R8", "valid in reset", sample_valid, 0);
        rst = 1'b0;
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in = 1'b0;
    endtask

    task automatic send_pair(int s);
        send_bit(s[1]);
        send_bit(s[0]);
    endtask

    task automatic wait_samples(int n);
        while (sample_no < n) @(negedge clk);
    endtask

    // compare samples [first, first+count) against symbol sym
    task automatic check_span(int first, int count, int sym, string req);
        int bad = 0;
        int bad_k = 0;
        wait_samples(first + count);
        for (int k = first; k < first + count; k++)
            if (cap[k] !== exp_code(sym, k) && bad == 0) begin
                bad = 1;
                bad_k = k;
            end
        chk(bad == 0, req, $sformatf("sample %0d sym %0d", bad_k, sym),
            cap[bad_k], exp_code(sym, bad_k));
    endtask

    task automatic t_idle_symbol();
        do_reset();
        // R8: symbol 00 after reset; R6: held and periodic
        check_span(0, 8, 0, "R8");
        check_span(8, 8, 0, "R6");
    endtask

    task automatic t_each_symbol();
        for (int s = 0; s < 4; s++) begin
            do_reset();
            send_pair(s);
            check_span(0, 8, 0, "R5");
            check_span(8, 16, s, (s == 2) ? "R3" : "R4");
        end
    endtask

    task automatic t_bit_order();
        // R1: 0 then 1 must be symbol 01, not 10
        do_reset();
        send_bit(1'b0);
        send_bit(1'b1);
        check_span(8, 8, 1, "R1");
    endtask

    task automatic t_late_pair();
        do_reset();
        send_pair(2);
        wait_samples(11);
        send_pair(1);
        // R5/R10: interval of 8 samples, change only after sample 15
        check_span(8, 8, 2, "R5");
        check_span(16, 8, 1, "R10");
    endtask

    task automatic t_lone_bit();
        do_reset();
        send_bit(1'b1);
        check_span(8, 8, 0, "R7");
        wait_samples(17);
        send_bit(1'b1);
        check_span(24, 8, 3, "R7");
    endtask

    task automatic t_ignore_invalid();
        do_reset();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            bit_in = ~bit_in;
        end
        bit_in = 1'b0;
        check_span(8, 8, 0, "R2");
    endtask

    task automatic t_reset_mid_pair();
        do_reset();
        send_bit(1'b1);
        do_reset();
        send_bit(1'b0);
        send_bit(1'b1);
        check_span(8, 8, 1, "R8");
    endtask

    task automatic t_overwrite();
        do_reset();
        send_pair(2);
        send_pair(3);
        check_span(8, 8, 3, "R11");
    endtask

    task automatic t_stream();
        int seq [0:3] = '{3, 1, 0, 2};
        do_reset();
        for (int p = 0; p < 4; p++) begin
            wait_samples(8 * p + 1);
            send_pair(seq[p]);
        end
        for (int p = 0; p < 4; p++)
            check_span(8 * (p + 1), 8, seq[p], "R5");
    endtask

    task automatic t_strobe();
        int gap = 0;
        do_reset();
        while (!sample_valid) @(negedge clk);
        @(negedge clk);
        chk(sample_valid == 1'b0, "R9", "strobe width", sample_valid, 0);
        gap = 1;
        while (!sample_valid && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        chk(gap == CPS, "R9", "strobe spacing", gap, CPS);
    endtask

    initial begin
        t_idle_symbol();
        t_each_symbol();
        t_bit_order();
        t_late_pair();
        t_lone_bit();
        t_ignore_invalid();
        t_reset_mid_pair();
        t_overwrite();
        t_stream();
        t_strobe();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule